// File: doc/BRIEF.md
# Interrupt Entry Sequencer (24-bit address mode)

This block carries out the processor's side of taking an interrupt while the core runs with 24-bit addresses. It watches two sources: a non-maskable line that is active low and reacts to its falling edge, and a maskable request level that arrives with an 8-bit vector byte supplied by the interrupting peripheral. When it takes one, it pulses a clear to both interrupt enable flags. It saves the current 24-bit program counter and a one-byte mode marker on a stack that grows downward, writing one byte per cycle through a byte-wide memory port.

For a maskable interrupt the sequencer then builds a table address from the interrupt page register and the vector byte. It reads a 16-bit handler address from that location, low byte first, and loads it into the program counter with the upper byte forced to zero. A non-maskable interrupt skips the table and jumps to a fixed restart address. A one-cycle done strobe marks the cycle in which the new program counter and stack pointer are valid.

Top module: `irq_entry_seq`

## Requirements
- R1: After reset, pc_out and sp_out are 0 and done, busy, ief_clr, mem_we and mem_re are all 0.
- R2: A maskable request is accepted only when the sequencer is idle and irq_req and ief1 are both 1 at the same clock edge. With ief1 = 0 the request is ignored: busy stays 0 and no memory access is made.
- R3: A falling edge on nmi_n is accepted at the first clock edge that sees nmi_n low, whatever the value of ief1.
- R4: When a non-maskable edge and an enabled maskable request arrive at the same edge, the non-maskable one is serviced. The maskable request is not serviced in the same entry.
- R5: ief_clr is high for exactly one cycle, the cycle after acceptance, which is also the cycle of the first stack write.
- R6: Entry makes four byte writes in consecutive cycles to sp-1, sp-2, sp-3 and sp-4, where sp is sp_in at acceptance. The bytes written are pc[23:16], pc[15:8], pc[7:0] and then 8'h01. sp_out ends at sp-4, modulo 2^24.
- R7: For a maskable entry, two reads follow the pushes. The first read is at {8'h00, page_reg, irq_vec} and the second at that address + 1 (24-bit sum). Read data is returned on mem_rdata in the cycle after the read request.
- R8: A maskable entry ends with pc_out = {8'h00, byte read second, byte read first} and done high for one cycle, 7 cycles after the accepting edge.
- R9: A non-maskable entry ends with pc_out = 24'h000066 and done high for one cycle, 4 cycles after the accepting edge.
- R10: A falling edge on nmi_n while an entry is in progress is remembered. It is accepted at the first edge after the sequencer returns to idle.
- R11: mem_we and mem_re are never high in the same cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| nmi_n | input | 1 | Non-maskable request, active low, edge sensitive |
| irq_req | input | 1 | Maskable request level |
| ief1 | input | 1 | Maskable interrupt enable flag |
| irq_vec | input | 8 | Vector byte from the requesting peripheral |
| page_reg | input | 8 | Interrupt page register |
| pc_in | input | 24 | Current program counter |
| sp_in | input | 24 | Current stack pointer |
| mem_rdata | input | 8 | Read data, valid the cycle after mem_re |
| mem_addr | output | 24 | Memory byte address |
| mem_wdata | output | 8 | Memory write data |
| mem_we | output | 1 | Memory write strobe |
| mem_re | output | 1 | Memory read strobe |
| pc_out | output | 24 | Program counter loaded by the entry |
| sp_out | output | 24 | Stack pointer after the pushes |
| ief_clr | output | 1 | One-cycle clear of both enable flags |
| busy | output | 1 | Entry sequence in progress |
| done | output | 1 | One-cycle strobe: pc_out and sp_out valid |

## Verification
Each result has a fixed due cycle, counted from the edge that accepts the request:
- ief_clr and the first stack write come 1 cycle later.
- The remaining pushes follow in the next three cycles.
- A non-maskable entry finishes with done 4 cycles after acceptance; a maskable one finishes 7 cycles after.

The bench drives inputs on the falling edge and samples once per cycle on the falling edge. It logs every write and read address it sees there. It requires done to be low in every cycle before the due cycle and high in exactly that cycle. The memory model in the bench returns read data one cycle after the request, so R7's latency is held by the model and not by the bench's timing.

// File: rtl/irq_entry_pkg.sv
package irq_entry_pkg;
  typedef enum logic [2:0] {
    ST_IDLE,
    ST_PUSH,
    ST_RD_LO,
    ST_RD_HI,
    ST_RD_WAIT
  } seq_st_e;
endpackage

// File: rtl/irq_entry_rst_sync.sv
module irq_entry_rst_sync (
  input  logic clk,
  input  logic rst_n,
  output logic rst_n_sync
);
  logic [1:0] sync_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) sync_q <= 2'b00;
    else        sync_q <= {sync_q[0], 1'b1};
  end

  assign rst_n_sync = sync_q[1];
endmodule

// File: rtl/irq_entry_nmi_edge.sv
module irq_entry_nmi_edge (
  input  logic clk,
  input  logic rst_n,
  input  logic nmi_n,
  input  logic taken,
  output logic nmi_hit
);
  logic lvl_q, pend_q;
  logic pend_d, fall;

  assign fall    = lvl_q & ~nmi_n;
  assign nmi_hit = pend_q | fall;

  always_comb begin
    pend_d = (pend_q | fall) & ~taken;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      lvl_q  <= 1'b1;
      pend_q <= 1'b0;
    end else begin
      lvl_q  <= nmi_n;
      pend_q <= pend_d;
    end
  end
endmodule

// File: rtl/irq_entry_memport.sv
module irq_entry_memport
  import irq_entry_pkg::*;
#(
  parameter int ADDR_W = 24,
  parameter int CNT_W  = 2,
  parameter logic [7:0] MODE_MARK = 8'h01
) (
  input  seq_st_e           st,
  input  logic [CNT_W-1:0]  push_idx,
  input  logic [ADDR_W-1:0] sp_cur,
  input  logic [ADDR_W-1:0] ret_pc,
  input  logic [ADDR_W-1:0] tbl_addr,
  output logic [ADDR_W-1:0] mem_addr,
  output logic [7:0]        mem_wdata,
  output logic              mem_we,
  output logic              mem_re
);
  localparam int PC_BYTES = ADDR_W / 8;

  logic [7:0] pc_byte [PC_BYTES];

  genvar g;
  generate
    for (g = 0; g < PC_BYTES; g++) begin : g_split
      assign pc_byte[g] = ret_pc[g*8 +: 8];
    end
  endgenerate

  always_comb begin
    mem_addr  = '0;
    mem_wdata = 8'h00;
    mem_we    = 1'b0;
    mem_re    = 1'b0;
    unique case (st)
      ST_PUSH: begin
        mem_we    = 1'b1;
        mem_addr  = sp_cur - ADDR_W'(1);
        mem_wdata = MODE_MARK;
        for (int i = 0; i < PC_BYTES; i++) begin
          if (push_idx == CNT_W'(i)) mem_wdata = pc_byte[PC_BYTES-1-i];
        end
      end
      ST_RD_LO: begin
        mem_re   = 1'b1;
        mem_addr = tbl_addr;
      end
      ST_RD_HI: begin
        mem_re   = 1'b1;
        mem_addr = tbl_addr + ADDR_W'(1);
      end
      default: ;
    endcase
  end
endmodule

// File: rtl/irq_entry_seq.sv
module irq_entry_seq
  import irq_entry_pkg::*;
#(
  parameter int ADDR_W = 24,
  parameter logic [ADDR_W-1:0] NMI_ADDR = 24'h000066,
  parameter logic [7:0] MODE_MARK = 8'h01
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              nmi_n,
  input  logic              irq_req,
  input  logic              ief1,
  input  logic [7:0]        irq_vec,
  input  logic [7:0]        page_reg,
  input  logic [ADDR_W-1:0] pc_in,
  input  logic [ADDR_W-1:0] sp_in,
  input  logic [7:0]        mem_rdata,
  output logic [ADDR_W-1:0] mem_addr,
  output logic [7:0]        mem_wdata,
  output logic              mem_we,
  output logic              mem_re,
  output logic [ADDR_W-1:0] pc_out,
  output logic [ADDR_W-1:0] sp_out,
  output logic              ief_clr,
  output logic              busy,
  output logic              done
);
  localparam int PC_BYTES  = ADDR_W / 8;
  localparam int CNT_W     = $clog2(PC_BYTES + 1);
  localparam int PUSH_LAST = PC_BYTES;

  logic rst_ns;

  seq_st_e           st_q, st_d;
  logic [CNT_W-1:0]  cnt_q, cnt_d;
  logic [ADDR_W-1:0] sp_q, sp_d, pc_q, pc_d, ret_q, ret_d, tbl_q, tbl_d;
  logic [7:0]        lo_q, lo_d;
  logic              is_nmi_q, is_nmi_d, done_q, done_d, clr_q, clr_d;
  logic              nmi_hit, take_nmi, take_irq;

  irq_entry_rst_sync u_rst (
    .clk        (clk),
    .rst_n      (rst_n),
    .rst_n_sync (rst_ns)
  );

  irq_entry_nmi_edge u_nmi (
    .clk     (clk),
    .rst_n   (rst_ns),
    .nmi_n   (nmi_n),
    .taken   (take_nmi),
    .nmi_hit (nmi_hit)
  );

  irq_entry_memport #(
    .ADDR_W    (ADDR_W),
    .CNT_W     (CNT_W),
    .MODE_MARK (MODE_MARK)
  ) u_port (
    .st        (st_q),
    .push_idx  (cnt_q),
    .sp_cur    (sp_q),
    .ret_pc    (ret_q),
    .tbl_addr  (tbl_q),
    .mem_addr  (mem_addr),
    .mem_wdata (mem_wdata),
    .mem_we    (mem_we),
    .mem_re    (mem_re)
  );

  assign take_nmi = (st_q == ST_IDLE) & nmi_hit;
  assign take_irq = (st_q == ST_IDLE) & ~nmi_hit & irq_req & ief1;

  // next-state logic
  always_comb begin
    st_d     = st_q;
    cnt_d    = cnt_q;
    sp_d     = sp_q;
    pc_d     = pc_q;
    ret_d    = ret_q;
    tbl_d    = tbl_q;
    lo_d     = lo_q;
    is_nmi_d = is_nmi_q;
    done_d   = 1'b0;
    clr_d    = 1'b0;
    unique case (st_q)
      ST_IDLE: begin
        if (take_nmi || take_irq) begin
          st_d     = ST_PUSH;
          cnt_d    = '0;
          ret_d    = pc_in;
          sp_d     = sp_in;
          tbl_d    = {{(ADDR_W-16){1'b0}}, page_reg, irq_vec};
          is_nmi_d = take_nmi;
          clr_d    = 1'b1;
        end
      end
      ST_PUSH: begin
        sp_d = sp_q - ADDR_W'(1);
        if (cnt_q == CNT_W'(PUSH_LAST)) begin
          if (is_nmi_q) begin
            pc_d   = NMI_ADDR;
            done_d = 1'b1;
            st_d   = ST_IDLE;
          end else begin
            st_d = ST_RD_LO;
          end
        end else begin
          cnt_d = cnt_q + CNT_W'(1);
        end
      end
      ST_RD_LO: st_d = ST_RD_HI;
      ST_RD_HI: begin
        lo_d = mem_rdata;
        st_d = ST_RD_WAIT;
      end
      ST_RD_WAIT: begin
        pc_d   = {{(ADDR_W-16){1'b0}}, mem_rdata, lo_q};
        done_d = 1'b1;
        st_d   = ST_IDLE;
      end
      default: st_d = ST_IDLE;
    endcase
  end

  // registers
  always_ff @(posedge clk or negedge rst_ns) begin
    if (!rst_ns) begin
      st_q     <= ST_IDLE;
      cnt_q    <= '0;
      sp_q     <= '0;
      pc_q     <= '0;
      ret_q    <= '0;
      tbl_q    <= '0;
      lo_q     <= 8'h00;
      is_nmi_q <= 1'b0;
      done_q   <= 1'b0;
      clr_q    <= 1'b0;
    end else begin
      st_q     <= st_d;
      cnt_q    <= cnt_d;
      sp_q     <= sp_d;
      pc_q     <= pc_d;
      ret_q    <= ret_d;
      tbl_q    <= tbl_d;
      lo_q     <= lo_d;
      is_nmi_q <= is_nmi_d;
      done_q   <= done_d;
      clr_q    <= clr_d;
    end
  end

  assign pc_out  = pc_q;
  assign sp_out  = sp_q;
  assign done    = done_q;
  assign ief_clr = clr_q;
  assign busy    = (st_q != ST_IDLE);
endmodule

// File: rtl/irq_entry_chk.sv
module irq_entry_chk #(
  parameter int ADDR_W = 24
) (
  input logic              clk,
  input logic              rst_n,
  input logic              mem_we,
  input logic              mem_re,
  input logic [ADDR_W-1:0] mem_addr,
  input logic [ADDR_W-1:0] sp_out,
  input logic [ADDR_W-1:0] pc_out,
  input logic              ief_clr,
  input logic              busy,
  input logic              done
);
  // R11
  a_r11_single_access: assert property (@(posedge clk) disable iff (!rst_n)
    !(mem_we && mem_re));

  // R6
  a_r6_write_below_sp: assert property (@(posedge clk) disable iff (!rst_n)
    mem_we |-> mem_addr == sp_out - ADDR_W'(1));

  // R6
  a_r6_sp_steps_down: assert property (@(posedge clk) disable iff (!rst_n)
    mem_we |=> sp_out == $past(sp_out) - ADDR_W'(1));

  // R5
  a_r5_clear_with_first_push: assert property (@(posedge clk) disable iff (!rst_n)
    ief_clr |-> busy && mem_we);

  // R5
  a_r5_clear_one_cycle: assert property (@(posedge clk) disable iff (!rst_n)
    ief_clr |=> !ief_clr);

  // R8
  a_r8_done_single: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);

  // R8
  a_r8_upper_zero: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> (pc_out[ADDR_W-1:16] == '0) && !busy);
endmodule

bind irq_entry_seq irq_entry_chk #(.ADDR_W(ADDR_W)) u_chk (
  .clk      (clk),
  .rst_n    (rst_n),
  .mem_we   (mem_we),
  .mem_re   (mem_re),
  .mem_addr (mem_addr),
  .sp_out   (sp_out),
  .pc_out   (pc_out),
  .ief_clr  (ief_clr),
  .busy     (busy),
  .done     (done)
);

// File: tb/irq_entry_seq_tb_top.sv
module irq_entry_seq_tb_top;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        nmi_n = 1'b1;
  logic        irq_req = 1'b0;
  logic        ief1 = 1'b0;
  logic [7:0]  irq_vec = 8'h00;
  logic [7:0]  page_reg = 8'h00;
  logic [23:0] pc_in = '0;
  logic [23:0] sp_in = '0;
  logic [7:0]  mem_rdata = 8'h00;
  logic [23:0] mem_addr, pc_out, sp_out;
  logic [7:0]  mem_wdata;
  logic        mem_we, mem_re, ief_clr, busy, done;

  int errors = 0;
  int checks = 0;
  bit clash  = 1'b0;

  logic [23:0] wa[$];
  logic [7:0]  wd[$];
  logic [23:0] ra[$];
  logic        rd_pend = 1'b0;
  logic [23:0] rd_pend_a = '0;

  always #10 clk = ~clk;

  irq_entry_seq dut_i (
    .clk(clk), .rst_n(rst_n), .nmi_n(nmi_n), .irq_req(irq_req), .ief1(ief1),
    .irq_vec(irq_vec), .page_reg(page_reg), .pc_in(pc_in), .sp_in(sp_in),
    .mem_rdata(mem_rdata), .mem_addr(mem_addr), .mem_wdata(mem_wdata),
    .mem_we(mem_we), .mem_re(mem_re), .pc_out(pc_out), .sp_out(sp_out),
    .ief_clr(ief_clr), .busy(busy), .done(done)
  );

  function automatic logic [7:0] tbl(input logic [23:0] a);
    return a[7:0] ^ a[15:8] ^ a[23:16] ^ 8'hA5;
  endfunction

  // memory model and access log, all on the falling edge
  always @(negedge clk) begin
    if (rd_pend) mem_rdata = tbl(rd_pend_a);
    rd_pend   = mem_re;
    rd_pend_a = mem_addr;
    if (mem_we) begin wa.push_back(mem_addr); wd.push_back(mem_wdata); end
    if (mem_re) ra.push_back(mem_addr);
    if (mem_we && mem_re) clash = 1'b1;
  end

  task automatic chk(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  // One entry. Called at a falling edge; returns at the falling edge after done.
  task automatic service(input bit use_nmi, input bit also_irq, input bit pulse_late_nmi);
    logic [23:0] pc, sp, ta, exp_pc;
    int wb, rb, lat;
    pc = 24'($urandom); sp = sp_in; ta = {8'h00, page_reg, irq_vec};
    pc_in = pc;
    wb = wa.size(); rb = ra.size();
    if (use_nmi) begin nmi_n = 1'b0; ief1 = 1'($urandom); irq_req = also_irq; if (also_irq) ief1 = 1'b1; end
    else begin irq_req = 1'b1; ief1 = 1'b1; end
    @(negedge clk);
    irq_req = 1'b0; ief1 = 1'b0;
    chk(busy == 1'b1, use_nmi ? "R3 accept" : "R2 accept", 32'(busy), 1);
    chk(ief_clr == 1'b1, "R5 ief_clr", 32'(ief_clr), 1);
    lat = use_nmi ? 4 : 7;
    for (int k = 1; k < lat; k++) begin
      @(negedge clk);
      if (k == 1) chk(ief_clr == 1'b0, "R5 ief_clr width", 32'(ief_clr), 0);
      if (done) chk(1'b0, "R8/R9 early done", 32'(k), 32'(lat));
      if (pulse_late_nmi && k == 2) nmi_n = 1'b0;
      if (pulse_late_nmi && k == 3) nmi_n = 1'b1;
    end
    @(negedge clk);
    if (use_nmi) exp_pc = 24'h000066;
    else exp_pc = {8'h00, tbl(ta + 24'd1), tbl(ta)};
    chk(done == 1'b1, use_nmi ? "R9 done due" : "R8 done due", 32'(done), 1);
    chk(pc_out == exp_pc, use_nmi ? "R9 pc" : "R8 pc", 32'(pc_out), 32'(exp_pc));
    chk(sp_out == sp - 24'd4, "R6 sp_out", 32'(sp_out), 32'(sp - 24'd4));
    chk(wa.size() - wb == 4, "R6 write count", 32'(wa.size() - wb), 4);
    if (wa.size() - wb == 4) begin
      for (int i = 0; i < 4; i++) begin
        logic [7:0] eb;
        eb = (i == 3) ? 8'h01 : pc[23 - 8*i -: 8];
        chk(wa[wb+i] == sp - 24'(i + 1), "R6 push addr", 32'(wa[wb+i]), 32'(sp - 24'(i + 1)));
        chk(wd[wb+i] == eb, "R6 push data", 32'(wd[wb+i]), 32'(eb));
      end
    end
    if (use_nmi) chk(ra.size() == rb, "R9 no table read", 32'(ra.size() - rb), 0);
    else begin
      chk(ra.size() - rb == 2, "R7 read count", 32'(ra.size() - rb), 2);
      if (ra.size() - rb == 2) begin
        chk(ra[rb] == ta, "R7 low addr", 32'(ra[rb]), 32'(ta));
        chk(ra[rb+1] == ta + 24'd1, "R7 high addr", 32'(ra[rb+1]), 32'(ta + 24'd1));
      end
    end
    nmi_n = 1'b1;
    sp_in = sp - 24'd4;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    errors++;
    $display("FAIL watchdog expired");
    $display("  Result: errors=%0d of %0d checks", errors, checks + 1);
    $finish;
  end

  initial begin
    void'($urandom(32'd1234));
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    // R1
    chk(pc_out == 0 && sp_out == 0, "R1 reset regs", 32'(pc_out ^ sp_out), 0);
    chk(!done && !busy && !ief_clr && !mem_we && !mem_re, "R1 reset strobes",
        {27'd0, done, busy, ief_clr, mem_we, mem_re}, 0);

    // R2: disabled maskable request ignored
    irq_req = 1'b1; ief1 = 1'b0;
    begin
      int w0;
      w0 = wa.size() + ra.size();
      repeat (6) @(negedge clk);
      chk(!busy && (wa.size() + ra.size() == w0), "R2 ignored when ief1=0",
          32'(wa.size() + ra.size() - w0), 0);
    end
    irq_req = 1'b0;
    @(negedge clk);

    // directed: table address crossing a page, stack wrapping below zero
    page_reg = 8'hFF; irq_vec = 8'hFF; sp_in = 24'h000002;
    service(1'b0, 1'b0, 1'b0);
    @(negedge clk);
    chk(done == 1'b0, "R8 done pulse", 32'(done), 0);

    // R3: NMI with ief1 random
    service(1'b1, 1'b0, 1'b0);
    @(negedge clk);

    // R4: NMI and maskable at the same edge
    page_reg = 8'h12; irq_vec = 8'h34;
    service(1'b1, 1'b1, 1'b0);
    repeat (3) @(negedge clk);
    chk(!busy, "R4 maskable not taken later", 32'(busy), 0);

    // R10: NMI edge during a maskable entry waits until idle
    begin
      logic [23:0] sp0;
      int wb;
      service(1'b0, 1'b0, 1'b1);
      sp0 = sp_in; wb = wa.size();
      chk(busy == 1'b0, "R10 idle after done", 32'(busy), 0);
      @(negedge clk);
      chk(busy == 1'b1, "R10 pending taken", 32'(busy), 1);
      repeat (4) @(negedge clk);
      chk(done && pc_out == 24'h000066, "R10 pending serviced as NMI", 32'(pc_out), 32'h66);
      chk(wa.size() - wb == 4 && wd[wa.size()-1] == 8'h01, "R10 pending pushes",
          32'(wa.size() - wb), 4);
      sp_in = sp0 - 24'd4;
      @(negedge clk);
    end

    // random mix
    for (int n = 0; n < 24; n++) begin
      page_reg = 8'($urandom); irq_vec = 8'($urandom); sp_in = 24'($urandom);
      service(1'($urandom), 1'b0, 1'b0);
      repeat (1 + $urandom % 3) @(negedge clk);
    end

    chk(!clash, "R11 single access", 32'(clash), 0);
    $display("  Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule